// File: doc/BRIEF.md
# Four-Bank SDRAM Command Timing Monitor

This block sits beside an SDRAM controller and watches the command pins it drives: chip select, the three strobes, address bit 10 and the two bank-select bits. For each of the four banks it keeps a state (idle, opening, open, closing) and a set of down-counters, one per timing rule. Every command it sees is judged legal or illegal in the cycle it is sampled. The block also reports, one cycle ahead, which banks would accept an activate, a column access or a precharge on the next edge.

All minimum delays are parameters in picoseconds. They are turned into clock counts by rounding up against a clock-period parameter. A column command issued with address bit 10 high leaves a pending automatic close, which the monitor starts at the cycle the burst timing calls for. An illegal command leaves every bank untouched. It sets a sticky error flag that holds the code of the first fault. A row that stays open past its maximum lifetime is reported the same way.

Top module: `bank_timing_monitor`

## Requirements
- R1: A command is sampled at a rising edge when `csN` is low and `rasN`/`casN`/`weN` are not all high; `cmdSeen` is high in the following cycle. With `csN` high, or with a no-op, `cmdSeen` stays low and no bank state moves. Pending work such as an automatic close keeps running.
- R2: `bankState[2b+1:2b]` gives bank b as 0 idle, 1 opening (row-to-column delay running), 2 open, 3 closing (precharge delay running). After reset all banks are idle, `actReady` and `preReady` are all ones, `rwReady` is zero and the error flag is clear.
- R3: An activate (ras low, cas high, we high) is followed by a read (ras high, cas low, we high) or a write (ras high, cas low, we low) to that bank only at least ceil(tRCD/tCK) = 2 edges later. `rwReady[b]` is high in the cycle before such a command would be legal.
- R4: A precharge (ras low, cas high, we low) of an open bank is legal only at least ceil(tRAS/tCK) = 5 edges after its activate, and `preReady[b]` announces this. A precharge of a bank that is already closed is legal and changes nothing.
- R5: An activate needs its bank closed for at least ceil(tRP/tCK) = 2 edges and at least ceil(tRC/tCK) = 6 edges since the previous activate of that bank. It also needs at least ceil(tRRD/tCK) = 2 edges since any activate. `actReady[b]` announces this.
- R6: On a precharge, `apBit` high closes every open bank; with `apBit` low, `bankSel` (0 to 3) names the one bank to close.
- R7: A read with `apBit` high closes its bank automatically BURST_LEN = 4 edges after the read. This is CAS_LAT-1 edges before the last data beat. A new activate of that bank is legal 4+2 = 6 edges after the read.
- R8: A write with `apBit` high closes its bank automatically BURST_LEN-1+WR_CLKS = 5 edges after the write, which is write recovery after the last beat. A new activate of that bank is legal 7 edges after the write.
- R9: While a bank's automatic close is pending, any activate, column command or precharge aimed at it, and any all-bank precharge, is illegal with code 6.
- R10: Refresh (ras low, cas low, we high) needs every bank closed, with the precharge and row-cycle delays done. Mode set (all three low) needs every bank closed and the precharge delay done. Otherwise the command is illegal with code 4. A refresh restarts the row-cycle delay of every bank.
- R11: An illegal command gives `cmdOk` low in the following cycle and changes no bank state. Codes: 1 column access too early or bank closed, 2 activate too early or bank open, 3 precharge before minimum row time.
- R12: `errFlag` is sticky until reset and `errCode` keeps the first fault's code, whatever follows.
- R13: A bank left open for more than floor(tRASmax/tCK) = 10000 cycles raises `errFlag` with code 5 one cycle after its open time reaches that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| apBit | input | 1 | Address bit 10: auto-close on column commands, all-bank on precharge |
| bankSel | input | 2 | Bank select |
| bankState | output | 8 | Two-bit state per bank, bank 0 in the low bits |
| actReady | output | 4 | Activate to bank b legal on next edge |
| rwReady | output | 4 | Read/write to bank b legal on next edge |
| preReady | output | 4 | Single-bank precharge of bank b legal on next edge |
| cmdSeen | output | 1 | A command was sampled on the last edge |
| cmdOk | output | 1 | The command sampled on the last edge was legal |
| errFlag | output | 1 | Sticky error indication |
| errCode | output | 3 | Code of the first error |

## Verification
Each timing rule is swept over the gap between two commands, from one edge upward past its limit, with a reset before each trial. At every gap the bench compares both the ready output and the legality verdict with a threshold computed from the picosecond parameters. This separates an off-by-one in counter loading from an error in the ready logic. The auto-close sweeps run the same gap scan after a read and after a write, which tells the two scheduling formulas apart. Directed sequences cover the remaining cases: single-bank against all-bank precharge, refresh and mode set with a bank open, illegal commands followed by legal ones (sticky first code), and a row held open past its maximum lifetime.

// File: rtl/bktm_pkg.sv
package bktm_pkg;

  localparam int NUM_BANKS = 4;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPENING = 2'd1,
    BK_OPEN    = 2'd2,
    BK_CLOSING = 2'd3
  } bankState_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_COLUMN    = 3'd1,
    ERR_ACTIVATE  = 3'd2,
    ERR_PRECHARGE = 3'd3,
    ERR_ALLIDLE   = 3'd4,
    ERR_OVERDUE   = 3'd5,
    ERR_AUTOPRE   = 3'd6
  } errCode_e;

  // Strobes from the command judge to the bank datapath; only legal commands pulse.
  typedef struct packed {
    logic       actEn;
    logic       rdEn;
    logic       wrEn;
    logic       apEn;
    logic       preOne;
    logic       preAll;
    logic       refEn;
    logic [1:0] bank;
  } bankStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bktm_banks.sv
module bktm_banks
  import bktm_pkg::*;
#(
  parameter int CLK_PS       = 10000,
  parameter int T_RCD_PS     = 15000,
  parameter int T_RP_PS      = 15000,
  parameter int T_RAS_PS     = 42000,
  parameter int T_RAS_MAX_PS = 100000000,
  parameter int T_RC_PS      = 60000,
  parameter int T_RRD_PS     = 14000,
  parameter int BURST_LEN    = 4,
  parameter int CAS_LAT      = 2,
  parameter int WR_CLKS      = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strobe,
  output logic [NUM_BANKS-1:0]   bankOpen,
  output logic [NUM_BANKS-1:0]   idleNow,
  output logic [NUM_BANKS-1:0]   rcDone,
  output logic [NUM_BANKS-1:0]   rwOk,
  output logic [NUM_BANKS-1:0]   preOk,
  output logic [NUM_BANKS-1:0]   apBusy,
  output logic [NUM_BANKS-1:0]   overdue,
  output logic                   rrdOk,
  output logic [2*NUM_BANKS-1:0] bankState,
  output logic [NUM_BANKS-1:0]   actReady,
  output logic [NUM_BANKS-1:0]   rwReady,
  output logic [NUM_BANKS-1:0]   preReady
);

  localparam int RCD_CLK    = ceilDiv(T_RCD_PS, CLK_PS);
  localparam int RP_CLK     = ceilDiv(T_RP_PS, CLK_PS);
  localparam int RAS_CLK    = ceilDiv(T_RAS_PS, CLK_PS);
  localparam int RC_CLK     = ceilDiv(T_RC_PS, CLK_PS);
  localparam int RRD_CLK    = ceilDiv(T_RRD_PS, CLK_PS);
  localparam int RASMAX_CLK = T_RAS_MAX_PS / CLK_PS;
  // Read auto-close leads the last beat (CAS_LAT + BURST_LEN - 1) by CAS_LAT - 1.
  localparam int RD_AP_DLY  = (CAS_LAT + BURST_LEN - 1) - (CAS_LAT - 1);
  // Write auto-close trails the last beat (BURST_LEN - 1) by write recovery.
  localparam int WR_AP_DLY  = (BURST_LEN - 1) + WR_CLKS;
  localparam int MAXLD      = maxOf(maxOf(maxOf(RCD_CLK, RP_CLK), maxOf(RAS_CLK, RC_CLK)),
                                    maxOf(RRD_CLK, maxOf(RD_AP_DLY, WR_AP_DLY))) - 1;
  localparam int CW         = (MAXLD < 1) ? 1 : $clog2(MAXLD + 1);
  localparam int AW         = $clog2(RASMAX_CLK + 1);

  typedef logic [CW-1:0] cnt_t;
  typedef logic [AW-1:0] age_t;

  function automatic cnt_t decSat(input cnt_t x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  cnt_t rrdQ;
  always_ff @(posedge clk) begin
    if (!rstN) rrdQ <= '0;
    else       rrdQ <= strobe.actEn ? cnt_t'(RRD_CLK - 1) : decSat(rrdQ);
  end
  assign rrdOk = (rrdQ == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic       openQ, apPendQ;
    cnt_t       rcdQ, rasMinQ, rcQ, rpQ, apCntQ;
    age_t       ageQ;
    logic       hitB, actB, colB, apB, apFire, preB;
    bankState_e stNow;

    assign hitB   = (strobe.bank == 2'(b));
    assign actB   = strobe.actEn && hitB;
    assign colB   = (strobe.rdEn || strobe.wrEn) && hitB;
    assign apB    = colB && strobe.apEn;
    assign apFire = apPendQ && (apCntQ == '0) && (rasMinQ == '0);
    assign preB   = (((strobe.preOne && hitB) || strobe.preAll) && openQ) || apFire;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ   <= 1'b0;
        apPendQ <= 1'b0;
        rcdQ    <= '0;
        rasMinQ <= '0;
        rcQ     <= '0;
        rpQ     <= '0;
        apCntQ  <= '0;
        ageQ    <= '0;
      end else begin
        rcdQ    <= actB ? cnt_t'(RCD_CLK - 1) : decSat(rcdQ);
        rasMinQ <= actB ? cnt_t'(RAS_CLK - 1) : decSat(rasMinQ);
        rcQ     <= (actB || strobe.refEn) ? cnt_t'(RC_CLK - 1) : decSat(rcQ);
        rpQ     <= preB ? cnt_t'(RP_CLK - 1) : decSat(rpQ);
        if (actB)      openQ <= 1'b1;
        else if (preB) openQ <= 1'b0;
        if (apB)         apPendQ <= 1'b1;
        else if (apFire) apPendQ <= 1'b0;
        apCntQ  <= apB ? (strobe.wrEn ? cnt_t'(WR_AP_DLY - 1) : cnt_t'(RD_AP_DLY - 1))
                       : decSat(apCntQ);
        if (actB)                                    ageQ <= '0;
        else if (openQ && ageQ != age_t'(RASMAX_CLK)) ageQ <= ageQ + 1'b1;
      end
    end

    always_comb begin
      if (openQ) stNow = (rcdQ != '0) ? BK_OPENING : BK_OPEN;
      else       stNow = (rpQ  != '0) ? BK_CLOSING : BK_IDLE;
    end

    assign bankState[2*b +: 2] = stNow;
    assign bankOpen[b] = openQ;
    assign idleNow[b]  = !openQ && (rpQ == '0);
    assign rcDone[b]   = (rcQ == '0);
    assign rwOk[b]     = openQ && (rcdQ == '0);
    assign preOk[b]    = (rasMinQ == '0);
    assign apBusy[b]   = apPendQ;
    assign overdue[b]  = openQ && (ageQ == age_t'(RASMAX_CLK));
    assign actReady[b] = !openQ && (rpQ == '0) && (rcQ == '0) && rrdOk;
    assign rwReady[b]  = openQ && (rcdQ == '0) && !apPendQ;
    assign preReady[b] = !openQ || ((rasMinQ == '0) && !apPendQ);

    p_col_needs_open_r3: assert property (@(posedge clk) disable iff (!rstN)
      colB |-> (openQ && rcdQ == '0 && !apPendQ));
    p_pre_after_rasmin_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.preOne && hitB && openQ) |-> (rasMinQ == '0));
    p_act_on_closed_r5: assert property (@(posedge clk) disable iff (!rstN)
      actB |-> (!openQ && rpQ == '0 && rcQ == '0 && rrdQ == '0));
    p_autopre_only_open_r7: assert property (@(posedge clk) disable iff (!rstN)
      apPendQ |-> openQ);
  end

endmodule

// File: rtl/bktm_ctrl.sv
module bktm_ctrl
  import bktm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 apBit,
  input  logic [1:0]           bankSel,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] idleNow,
  input  logic [NUM_BANKS-1:0] rcDone,
  input  logic [NUM_BANKS-1:0] rwOk,
  input  logic [NUM_BANKS-1:0] preOk,
  input  logic [NUM_BANKS-1:0] apBusy,
  input  logic [NUM_BANKS-1:0] overdue,
  input  logic                 rrdOk,
  output bankStrobe_t          strobe,
  output logic                 cmdSeen,
  output logic                 cmdOk,
  output logic                 errFlag,
  output logic [2:0]           errCode
);

  logic     isCmd, isAct, isRd, isWr, isPre, isRef, isMrs;
  errCode_e codeNow;
  logic     bad;

  assign isCmd = !csN && !(rasN && casN && weN);
  assign isAct = !csN && !rasN &&  casN &&  weN;
  assign isRd  = !csN &&  rasN && !casN &&  weN;
  assign isWr  = !csN &&  rasN && !casN && !weN;
  assign isPre = !csN && !rasN &&  casN && !weN;
  assign isRef = !csN && !rasN && !casN &&  weN;
  assign isMrs = !csN && !rasN && !casN && !weN;

  always_comb begin
    codeNow = ERR_NONE;
    if (isAct) begin
      if (apBusy[bankSel])                                      codeNow = ERR_AUTOPRE;
      else if (!(idleNow[bankSel] && rcDone[bankSel] && rrdOk)) codeNow = ERR_ACTIVATE;
    end else if (isRd || isWr) begin
      if (apBusy[bankSel])     codeNow = ERR_AUTOPRE;
      else if (!rwOk[bankSel]) codeNow = ERR_COLUMN;
    end else if (isPre) begin
      if (apBit) begin
        if (|apBusy)                  codeNow = ERR_AUTOPRE;
        else if (|(bankOpen & ~preOk)) codeNow = ERR_PRECHARGE;
      end else begin
        if (apBusy[bankSel])                          codeNow = ERR_AUTOPRE;
        else if (bankOpen[bankSel] && !preOk[bankSel]) codeNow = ERR_PRECHARGE;
      end
    end else if (isRef) begin
      if (!(&(idleNow & rcDone))) codeNow = ERR_ALLIDLE;
    end else if (isMrs) begin
      if (!(&idleNow)) codeNow = ERR_ALLIDLE;
    end
  end

  assign bad = (codeNow != ERR_NONE);

  always_comb begin
    strobe        = '0;
    strobe.bank   = bankSel;
    strobe.actEn  = isAct && !bad;
    strobe.rdEn   = isRd && !bad;
    strobe.wrEn   = isWr && !bad;
    strobe.apEn   = apBit;
    strobe.preOne = isPre && !apBit && !bad;
    strobe.preAll = isPre && apBit && !bad;
    strobe.refEn  = isRef && !bad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdSeen <= 1'b0;
      cmdOk   <= 1'b0;
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      cmdSeen <= isCmd;
      cmdOk   <= isCmd && !bad;
      if (!errFlag) begin
        if (bad) begin
          errFlag <= 1'b1;
          errCode <= codeNow;
        end else if (|overdue) begin
          errFlag <= 1'b1;
          errCode <= ERR_OVERDUE;
        end
      end
    end
  end

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && $stable(errCode)));
  p_ok_implies_seen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && bad) |=> (cmdSeen && !cmdOk));

endmodule

// File: rtl/bank_timing_monitor.sv
module bank_timing_monitor
  import bktm_pkg::*;
#(
  parameter int CLK_PS       = 10000,
  parameter int T_RCD_PS     = 15000,
  parameter int T_RP_PS      = 15000,
  parameter int T_RAS_PS     = 42000,
  parameter int T_RAS_MAX_PS = 100000000,
  parameter int T_RC_PS      = 60000,
  parameter int T_RRD_PS     = 14000,
  parameter int BURST_LEN    = 4,
  parameter int CAS_LAT      = 2,
  parameter int WR_CLKS      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       apBit,
  input  logic [1:0] bankSel,
  output logic [7:0] bankState,
  output logic [3:0] actReady,
  output logic [3:0] rwReady,
  output logic [3:0] preReady,
  output logic       cmdSeen,
  output logic       cmdOk,
  output logic       errFlag,
  output logic [2:0] errCode
);

  bankStrobe_t          strobe;
  logic [NUM_BANKS-1:0] bankOpen, idleNow, rcDone, rwOk, preOk, apBusy, overdue;
  logic                 rrdOk;

  bktm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .apBit(apBit), .bankSel(bankSel),
    .bankOpen(bankOpen), .idleNow(idleNow), .rcDone(rcDone),
    .rwOk(rwOk), .preOk(preOk), .apBusy(apBusy), .overdue(overdue), .rrdOk(rrdOk),
    .strobe(strobe),
    .cmdSeen(cmdSeen), .cmdOk(cmdOk), .errFlag(errFlag), .errCode(errCode)
  );

  bktm_banks #(
    .CLK_PS(CLK_PS), .T_RCD_PS(T_RCD_PS), .T_RP_PS(T_RP_PS),
    .T_RAS_PS(T_RAS_PS), .T_RAS_MAX_PS(T_RAS_MAX_PS), .T_RC_PS(T_RC_PS),
    .T_RRD_PS(T_RRD_PS), .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .WR_CLKS(WR_CLKS)
  ) u_banks (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bankOpen(bankOpen), .idleNow(idleNow), .rcDone(rcDone),
    .rwOk(rwOk), .preOk(preOk), .apBusy(apBusy), .overdue(overdue), .rrdOk(rrdOk),
    .bankState(bankState), .actReady(actReady), .rwReady(rwReady), .preReady(preReady)
  );

endmodule

// File: tb/test_bank_timing_monitor.sv
module test_bank_timing_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int TCK_PS  = 10000;
  localparam int TRCD    = (15000 + TCK_PS - 1) / TCK_PS;
  localparam int TRP     = (15000 + TCK_PS - 1) / TCK_PS;
  localparam int TRAS    = (42000 + TCK_PS - 1) / TCK_PS;
  localparam int TRC     = (60000 + TCK_PS - 1) / TCK_PS;
  localparam int TRRD    = (14000 + TCK_PS - 1) / TCK_PS;
  localparam int RASMAX  = 100000000 / TCK_PS;
  localparam int BL      = 4;
  localparam int WRREC   = 2;

  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, apBit = 1'b0;
  logic [1:0] bankSel = 2'd0;
  logic [7:0] bankState;
  logic [3:0] actReady, rwReady, preReady;
  logic cmdSeen, cmdOk, errFlag;
  logic [2:0] errCode;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_timing_monitor i_bank_timing_monitor (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .apBit(apBit), .bankSel(bankSel), .bankState(bankState),
    .actReady(actReady), .rwReady(rwReady), .preReady(preReady),
    .cmdSeen(cmdSeen), .cmdOk(cmdOk), .errFlag(errFlag), .errCode(errCode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c, input logic ap, input logic [1:0] bk);
    {csN, rasN, casN, weN} = c;
    apBit = ap;
    bankSel = bk;
    @(posedge clk);
    #1;
    {csN, rasN, casN, weN} = 4'b1111;
    apBit = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {csN, rasN, casN, weN} = 4'b1111;
    @(posedge clk);
    @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  function automatic logic [1:0] st(input int b);
    return bankState[2*b +: 2];
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    // R2: reset state
    doReset();
    chk("R2 state", bankState, 8'h00);
    chk("R2 actReady", actReady, 4'hF);
    chk("R2 rwReady", rwReady, 4'h0);
    chk("R2 preReady", preReady, 4'hF);
    chk("R2 errFlag", errFlag, 0);
    chk("R2 cmdSeen", cmdSeen, 0);

    // R1: deselect and no-op are not commands; burst stop and activate are
    issue(C_DES, 1'b0, 2'd0);
    chk("R1 deselect seen", cmdSeen, 0);
    chk("R1 deselect state", bankState, 8'h00);
    issue(C_NOP, 1'b0, 2'd0);
    chk("R1 nop seen", cmdSeen, 0);
    issue(C_BST, 1'b0, 2'd0);
    chk("R1 stop seen", cmdSeen, 1);
    chk("R1 stop ok", cmdOk, 1);
    issue(C_ACT, 1'b0, 2'd1);
    chk("R1 act seen", cmdSeen, 1);
    chk("R2 opening", st(1), 2'd1);
    idle(1);
    chk("R2 open", st(1), 2'd2);

    // R3: activate to column gap sweep
    for (int k = 1; k <= 6; k++) begin
      doReset();
      issue(C_ACT, 1'b0, 2'd0);
      idle(k - 1);
      chk("R3 rwReady", rwReady[0], (k >= TRCD));
      issue(C_RD, 1'b0, 2'd0);
      chk("R3 read legal", cmdOk, (k >= TRCD));
    end

    // R4 / R11: activate to precharge gap sweep; illegal leaves bank open
    for (int k = 1; k <= 8; k++) begin
      doReset();
      issue(C_ACT, 1'b0, 2'd0);
      idle(k - 1);
      chk("R4 preReady", preReady[0], (k >= TRAS));
      issue(C_PRE, 1'b0, 2'd0);
      chk("R4 pre legal", cmdOk, (k >= TRAS));
      chk("R11 state after pre", st(0), (k >= TRAS) ? 2'd3 : 2'd2);
      if (k < TRAS) chk("R11 code", errCode, 3'd3);
    end

    // R5: activate to activate on another bank
    for (int k = 1; k <= 4; k++) begin
      doReset();
      issue(C_ACT, 1'b0, 2'd0);
      idle(k - 1);
      chk("R5 rrd ready", actReady[1], (k >= TRRD));
      issue(C_ACT, 1'b0, 2'd1);
      chk("R5 rrd legal", cmdOk, (k >= TRRD));
    end

    // R5: precharge to activate on the same bank
    for (int k = 1; k <= 5; k++) begin
      doReset();
      issue(C_ACT, 1'b0, 2'd0);
      idle(TRAS - 1);
      issue(C_PRE, 1'b0, 2'd0);
      idle(k - 1);
      chk("R5 rp ready", actReady[0], (k >= TRP) && (TRAS + k >= TRC));
      issue(C_ACT, 1'b0, 2'd0);
      chk("R5 rp legal", cmdOk, (k >= TRP) && (TRAS + k >= TRC));
      if (!((k >= TRP) && (TRAS + k >= TRC))) chk("R11 act code", errCode, 3'd2);
    end

    // R10: refresh starts the row-cycle delay
    for (int k = 1; k <= 8; k++) begin
      doReset();
      issue(C_REF, 1'b0, 2'd0);
      chk("R10 ref legal", cmdOk, 1);
      idle(k - 1);
      issue(C_ACT, 1'b0, 2'd2);
      chk("R10 act after ref", cmdOk, (k >= TRC));
    end

    // R7: read with auto-close, then re-activate
    for (int k = 1; k <= 8; k++) begin
      doReset();
      issue(C_ACT, 1'b0, 2'd0);
      idle(TRCD - 1);
      issue(C_RD, 1'b1, 2'd0);
      idle(k - 1);
      issue(C_ACT, 1'b0, 2'd0);
      chk("R7 act after read-ap", cmdOk, (k >= BL + TRP));
    end
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(TRCD - 1);
    issue(C_RD, 1'b1, 2'd0);
    idle(BL - 1);
    chk("R7 still open", st(0), 2'd2);
    idle(1);
    chk("R7 closing", st(0), 2'd3);

    // R8: write with auto-close, then re-activate
    for (int k = 1; k <= 9; k++) begin
      doReset();
      issue(C_ACT, 1'b0, 2'd0);
      idle(TRCD - 1);
      issue(C_WR, 1'b1, 2'd0);
      idle(k - 1);
      issue(C_ACT, 1'b0, 2'd0);
      chk("R8 act after write-ap", cmdOk, (k >= BL - 1 + WRREC + TRP));
    end
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(TRCD - 1);
    issue(C_WR, 1'b1, 2'd0);
    idle(BL - 1 + WRREC - 1);
    chk("R8 still open", st(0), 2'd2);
    idle(1);
    chk("R8 closing", st(0), 2'd3);

    // R9: column command to a bank with pending auto-close
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(TRCD - 1);
    issue(C_RD, 1'b1, 2'd0);
    chk("R9 rwReady low", rwReady[0], 0);
    issue(C_RD, 1'b0, 2'd0);
    chk("R9 read refused", cmdOk, 0);
    chk("R9 code", errCode, 3'd6);

    // R6: single-bank precharge by bank select
    doReset();
    issue(C_ACT, 1'b0, 2'd2);
    idle(TRRD - 1);
    issue(C_ACT, 1'b0, 2'd3);
    idle(TRAS - 1);
    issue(C_PRE, 1'b0, 2'd3);
    chk("R6 single legal", cmdOk, 1);
    chk("R6 bank3 closing", st(3), 2'd3);
    chk("R6 bank2 open", st(2), 2'd2);
    // R6: all-bank precharge
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(TRRD - 1);
    issue(C_ACT, 1'b0, 2'd1);
    idle(TRAS - 1);
    issue(C_PRE, 1'b1, 2'd3);
    chk("R6 all legal", cmdOk, 1);
    chk("R6 all states", bankState, 8'h0F);

    // R10: refresh and mode set with a bank open
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(1);
    issue(C_REF, 1'b0, 2'd0);
    chk("R10 ref open refused", cmdOk, 0);
    chk("R10 code", errCode, 3'd4);
    issue(C_MRS, 1'b0, 2'd0);
    chk("R10 mrs open refused", cmdOk, 0);
    doReset();
    issue(C_MRS, 1'b0, 2'd0);
    chk("R10 mrs idle legal", cmdOk, 1);
    issue(C_REF, 1'b0, 2'd0);
    issue(C_REF, 1'b0, 2'd0);
    chk("R10 back-to-back ref refused", cmdOk, 0);

    // R12: sticky first code
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    issue(C_PRE, 1'b0, 2'd0);
    chk("R12 flag", errFlag, 1);
    chk("R12 code", errCode, 3'd3);
    issue(C_RD, 1'b0, 2'd0);
    chk("R12 legal read", cmdOk, 1);
    issue(C_ACT, 1'b0, 2'd0);
    chk("R12 still flagged", errFlag, 1);
    chk("R12 first code kept", errCode, 3'd3);

    // R13: row held open too long
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(RASMAX);
    chk("R13 not yet", errFlag, 0);
    idle(1);
    chk("R13 flag", errFlag, 1);
    chk("R13 code", errCode, 3'd5);
    doReset();
    issue(C_ACT, 1'b0, 2'd0);
    idle(TRAS - 1);
    issue(C_PRE, 1'b0, 2'd0);
    idle(RASMAX + 2);
    chk("R13 closed row no error", errFlag, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule